// File: doc/BRIEF.md
# Accumulating Bit-Serial Adder

The block adds two WIDTH-bit numbers one bit per clock. It uses one full adder, a carry flip-flop and two right-shifting registers. The accumulator register holds the augend and the operand register holds the addend. On each shift the full adder combines the low bit of each register with the stored carry. The sum bit enters the accumulator at its top as the accumulator shifts right. The carry-out goes back into the carry flip-flop. The result therefore replaces the augend in place.

While the operand register shifts out its addend, it takes in the next operand on a serial input, least significant bit first. A new start then adds that fresh operand to the running total without a parallel reload. This lets a chain of numbers accumulate. A start with the clear option zeroes the accumulator, so the operand passes into it unchanged.

A controller counts exactly WIDTH shifts after each start. It stretches the count across any cycles where the shift enable is low. After the last shift it raises `done`, and the final carry can then be read.

Top module: `serial_accum_adder`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator, the operand register, the carry, `busy` and `done` all become 0.
- R2: When idle (`busy` low, `start` low), `loadA` copies `dataA` into the accumulator and `loadB` copies `dataB` into the operand register, effective at the next edge.
- R3: `start` clears the carry and `done`, sets `busy` at the next edge and restarts the shift count; it takes priority over loads and shifts.
- R4: `start` with `clearAcc` high also sets the accumulator to zero.
- R5: Each shift puts A[0] xor B[0] xor carry into accumulator bit WIDTH-1, moves A right by one, and stores the majority of the three as the new carry.
- R6: Each shift moves the operand register right by one, with `serialInB` entering bit WIDTH-1.
- R7: While `busy` and `shiftEn` is low, the accumulator and the carry hold, and the pause does not count toward the WIDTH shifts.
- R8: After exactly WIDTH shifts, `busy` falls and `done` rises at the same edge. `sumA` then equals (A+B) mod 2^WIDTH and `carryOut` equals bit WIDTH of A+B.
- R9: `loadA` and `loadB` have no effect while `busy` is high.
- R10: `done` stays high until the next `start` or reset, including across idle loads.
- R11: An operand fed serially, LSB first, during one addition is added to the accumulator by the next `start` without clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| loadA | input | 1 | Parallel load of the accumulator when idle |
| dataA | input | WIDTH | Parallel value for the accumulator |
| loadB | input | 1 | Parallel load of the operand register when idle |
| dataB | input | WIDTH | Parallel value for the operand register |
| serialInB | input | 1 | Bit entering the operand register top on each shift |
| shiftEn | input | 1 | Permits a shift on this edge while busy |
| start | input | 1 | Begins an addition of WIDTH shifts |
| clearAcc | input | 1 | With start, zeroes the accumulator |
| sumA | output | WIDTH | Parallel view of the accumulator |
| carryOut | output | 1 | Carry flip-flop; final carry once done |
| busy | output | 1 | Addition in progress |
| done | output | 1 | Addition finished |

## Verification
Loads and `start` take effect one edge after they are driven. Each shift updates `sumA` and `carryOut` one edge after `shiftEn` is sampled high. `done` and the final sum appear at the same edge as the WIDTH-th enabled shift. The bench drives inputs on the falling edge and reads outputs at the next falling edge, so every check falls exactly one rising edge after its stimulus. Pause cycles are counted in the bench, so the final check moves back by exactly the number of paused edges.

// File: rtl/sadd_pkg.sv
package sadd_pkg;
  typedef struct packed {
    logic clrCarry;
    logic clrA;
    logic shift;
    logic loadA;
    logic loadB;
  } sadd_strobe_t;
endpackage

// File: rtl/sadd_ctrl.sv
module sadd_ctrl
  import sadd_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         clearAcc,
  input  logic         shiftEn,
  input  logic         loadA,
  input  logic         loadB,
  output sadd_strobe_t strobe,
  output logic         busy,
  output logic         done
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  logic [CNT_W-1:0] shiftCnt;
  logic             doShift;

  assign doShift = busy && shiftEn && !start;

  always_comb begin
    strobe          = '0;
    strobe.clrCarry = start;
    strobe.clrA     = start && clearAcc;
    strobe.shift    = doShift;
    strobe.loadA    = loadA && !busy && !start;
    strobe.loadB    = loadB && !busy && !start;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftCnt <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else if (start) begin
      shiftCnt <= '0;
      busy     <= 1'b1;
      done     <= 1'b0;
    end else if (doShift) begin
      shiftCnt <= shiftCnt + 1'b1;
      if (shiftCnt == LAST) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sadd_datapath.sv
module sadd_datapath
  import sadd_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  sadd_strobe_t     strobe,
  input  logic [WIDTH-1:0] dataA,
  input  logic [WIDTH-1:0] dataB,
  input  logic             serialInB,
  output logic [WIDTH-1:0] regA,
  output logic [WIDTH-1:0] regB,
  output logic             carry
);
  logic sumBit;
  logic carryNext;

  always_comb begin
    sumBit    = regA[0] ^ regB[0] ^ carry;
    carryNext = (regA[0] & regB[0]) | (regA[0] & carry) | (regB[0] & carry);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regA  <= '0;
      regB  <= '0;
      carry <= 1'b0;
    end else if (strobe.clrCarry) begin
      carry <= 1'b0;
      if (strobe.clrA) regA <= '0;
    end else if (strobe.shift) begin
      regA  <= {sumBit, regA[WIDTH-1:1]};
      regB  <= {serialInB, regB[WIDTH-1:1]};
      carry <= carryNext;
    end else begin
      if (strobe.loadA) regA <= dataA;
      if (strobe.loadB) regB <= dataB;
    end
  end
endmodule

// File: rtl/serial_accum_adder.sv
module serial_accum_adder
  import sadd_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loadA,
  input  logic [WIDTH-1:0] dataA,
  input  logic             loadB,
  input  logic [WIDTH-1:0] dataB,
  input  logic             serialInB,
  input  logic             shiftEn,
  input  logic             start,
  input  logic             clearAcc,
  output logic [WIDTH-1:0] sumA,
  output logic             carryOut,
  output logic             busy,
  output logic             done
);
  sadd_strobe_t     strobe;
  logic [WIDTH-1:0] regB;

  sadd_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .clearAcc(clearAcc),
    .shiftEn(shiftEn), .loadA(loadA), .loadB(loadB),
    .strobe(strobe), .busy(busy), .done(done)
  );

  sadd_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .dataA(dataA), .dataB(dataB),
    .serialInB(serialInB), .regA(sumA), .regB(regB), .carry(carryOut)
  );
endmodule

// File: rtl/sadd_chk.sv
module sadd_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             clearAcc,
  input logic             shiftEn,
  input logic             serialInB,
  input logic [WIDTH-1:0] sumA,
  input logic [WIDTH-1:0] regB,
  input logic             carryOut,
  input logic             busy,
  input logic             done
);
  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (sumA == '0 && regB == '0 && !carryOut && !busy && !done));
  // R3
  start_arms_chk: assert property (@(posedge clk) disable iff (rst) start |=> (busy && !done && !carryOut));
  // R4
  clear_acc_chk: assert property (@(posedge clk) disable iff (rst) (start && clearAcc) |=> sumA == '0);
  // R5
  sum_bit_chk: assert property (@(posedge clk) disable iff (rst) (busy && shiftEn && !start) |=>
    (sumA[WIDTH-1] == ($past(sumA[0]) ^ $past(regB[0]) ^ $past(carryOut))) &&
    (carryOut == (($past(sumA[0]) & $past(regB[0])) | ($past(sumA[0]) & $past(carryOut)) | ($past(regB[0]) & $past(carryOut)))));
  // R6
  serial_in_chk: assert property (@(posedge clk) disable iff (rst) (busy && shiftEn && !start) |=>
    regB[WIDTH-1] == $past(serialInB));
  // R7
  pause_hold_chk: assert property (@(posedge clk) disable iff (rst) (busy && !shiftEn && !start) |=>
    ($stable(sumA) && $stable(carryOut) && $stable(regB) && busy));
  // R8
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst) !(busy && done));
  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (rst) (done && !start) |=> done);
endmodule

bind serial_accum_adder sadd_chk #(.WIDTH(WIDTH)) u_sadd_chk (
  .clk(clk), .rst(rst), .start(start), .clearAcc(clearAcc), .shiftEn(shiftEn),
  .serialInB(serialInB), .sumA(sumA), .regB(regB), .carryOut(carryOut),
  .busy(busy), .done(done)
);

// File: tb/test_serial_accum_adder.sv
module test_serial_accum_adder;
  localparam int W = 4;
  localparam int M = 1 << W;

  logic clk = 1'b0;
  logic rst, loadA, loadB, serialInB, shiftEn, start, clearAcc;
  logic [W-1:0] dataA, dataB, sumA;
  logic carryOut, busy, done;
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  serial_accum_adder #(.WIDTH(W)) i_serial_accum_adder (
    .clk(clk), .rst(rst), .loadA(loadA), .dataA(dataA), .loadB(loadB), .dataB(dataB),
    .serialInB(serialInB), .shiftEn(shiftEn), .start(start), .clearAcc(clearAcc),
    .sumA(sumA), .carryOut(carryOut), .busy(busy), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    loadA = 0; loadB = 0; start = 0; clearAcc = 0; shiftEn = 0; serialInB = 0;
  endtask

  task automatic loadBoth(input int a, input int b);
    @(negedge clk); idle(); loadA = 1; dataA = W'(a); loadB = 1; dataB = W'(b);
    @(negedge clk); idle();
  endtask

  // start then WIDTH enabled shifts feeding value fb serially; checks done and sum
  task automatic runAdd(input bit clr, input int fb, input int expSum, input int expCarry, input string req);
    idle(); start = 1; clearAcc = clr;
    @(negedge clk); idle();
    for (int k = 0; k < W; k++) begin
      shiftEn = 1; serialInB = fb[k];
      @(negedge clk); idle();
    end
    check({req, " sum"}, int'(sumA), expSum);
    check({req, " carry"}, int'(carryOut), expCarry);
    check({req, " done"}, int'(done), 1);
    check({req, " busy"}, int'(busy), 0);
  endtask

  initial begin
    idle(); dataA = '0; dataB = '0;
    rst = 1;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check("R1 sumA", int'(sumA), 0);
    check("R1 carry", int'(carryOut), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    rst = 0;

    // R2 idle load visible next edge
    @(negedge clk); loadA = 1; dataA = 4'd9;
    @(negedge clk); idle();
    check("R2 loadA", int'(sumA), 9);

    // R3, R5 first shift step
    loadBoth(5, 3);
    start = 1;
    @(negedge clk); idle();
    check("R3 busy after start", int'(busy), 1);
    check("R3 carry cleared", int'(carryOut), 0);
    shiftEn = 1;
    @(negedge clk); idle();
    check("R5 first shift sumA", int'(sumA), (0 << 3) | (5 >> 1)); // 1^1=0 into MSB
    check("R5 first carry", int'(carryOut), 1);
    // R7 pause with R9 loads while busy
    loadA = 1; dataA = 4'd15; loadB = 1; dataB = 4'd15;
    @(negedge clk);
    @(negedge clk); idle();
    check("R7 pause holds sumA", int'(sumA), 2);
    check("R7 pause holds carry", int'(carryOut), 1);
    check("R9 busy ignores loads", int'(busy), 1);
    for (int k = 1; k < W; k++) begin
      shiftEn = 1;
      @(negedge clk); idle();
    end
    check("R7 R9 paused sum", int'(sumA), 8);
    check("R8 done after count", int'(done), 1);
    // R10 done holds across idle loads
    @(negedge clk); loadA = 1; dataA = 4'd2;
    @(negedge clk); idle();
    @(negedge clk);
    check("R10 done held", int'(done), 1);
    check("R2 idle loadA after done", int'(sumA), 2);

    // R4 clear start: B passes into A
    loadBoth(11, 6);
    runAdd(1'b1, 0, 6, 0, "R4 clearAcc");

    // R8 R6 R11 exhaustive sweep with chained accumulation
    for (int a = 0; a < M; a++) begin
      for (int b = 0; b < M; b++) begin
        int c, s1;
        c = (a * 3 + b * 5 + 1) % M;
        s1 = a + b;
        loadBoth(a, b);
        runAdd(1'b0, c, s1 % M, s1 / M, "R8 R6");
        runAdd(1'b0, 0, ((s1 % M) + c) % M, ((s1 % M) + c) / M, "R11 chain");
      end
    end

    // R1 reset mid-operation
    loadBoth(7, 7);
    start = 1;
    @(negedge clk); idle(); shiftEn = 1;
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0; idle();
    check("R1 reset sumA", int'(sumA), 0);
    check("R1 reset busy", int'(busy), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule